// File: doc/BRIEF.md
# Segment Selector Address Translator

This block turns a segment-relative offset into a 32-bit linear address. Six selector registers are held inside: code (CS), data (DS), stack (SS) and three extra segments (ES, FS, GS). Each selector names one descriptor in either a global or a local descriptor table. A descriptor gives a base, a limit, execute/read/write rights and a descriptor ring. Both tables sit in one block RAM and are filled through a simple write port. Only ring-0 writers may change the tables.

A request carries an access kind, an optional segment override, the ring of the requester and the offset. Without an override, the segment comes from the kind of access: a fetch uses CS, a push or pop uses SS, and a load or store uses DS. The block adds the descriptor base to the offset, wrapping modulo 2^32. It checks the selector, the ring, the rights and the limit. It then returns the linear address or a fault code. With base 0 and limit 0xFFFFFFFF the mapping is the identity (flat mode). A negative base moves a high-linked region down to low memory.

Requests use a valid/ready handshake. A request that is accepted on a clock edge produces its response in the following cycle. The response is held until the consumer takes it.

Top module: `seg_xlate_top`

## Requirements
- R1: After reset, rsp_valid is 0, req_ready is 1, and all six selector registers hold 0x0000. Any access then returns fault code 1 (descriptor fault) with rsp_lin = 0.
- R2: A request accepted (req_valid and req_ready high) on a clock edge makes rsp_valid 1 after that edge. req_ready = !rsp_valid | rsp_ready. While rsp_valid is 1 and rsp_ready is 0, rsp_lin, rsp_fault and rsp_seg stay stable.
- R3: With req_ovr_en = 0, the implicit segment is chosen from req_kind. The encodings are load=0, store=1, fetch=2, push=3, pop=4. Fetch (2) selects CS (id 0). Push (3) and pop (4) select SS (id 2). Load (0), store (1) and any other code select DS (id 1). The chosen id appears on rsp_seg.
- R4: With req_ovr_en = 1, req_ovr_id selects the segment: CS=0, DS=1, SS=2, ES=3, FS=4, GS=5. Ids 6 and 7 return fault code 1. The extra segments ES, FS and GS are reached only in this way.
- R5: With no fault, rsp_lin = (descriptor base + offset) mod 2^32.
- R6: A selector is decoded as follows. Bits [15:3] are the table index. Bit 2 picks the table (0 global, 1 local). Bits [1:0] are the requested ring. The effective ring is the larger of req_ring and the selector ring.
- R7: A selector with bit 2 = 0 and index 0 (the null descriptor) returns fault code 1. So does any index at or beyond the table depth (16 entries per table by default). Local index 0 is an ordinary entry.
- R8: An offset greater than the descriptor limit returns fault code 4 (limit fault). An offset equal to the limit is allowed.
- R9: Rights are written as tbl_rights bit 2 = execute, bit 1 = read, bit 0 = write. A fetch needs execute, a store or push needs write, and a load or pop needs read. A missing right returns fault code 3 (protection fault).
- R10: An effective ring numerically greater than the descriptor ring (tbl_dpl) returns fault code 2 (privilege fault).
- R11: When several faults apply, the reported one is the first in this order: descriptor (1), privilege (2), protection (3), limit (4). Any fault forces rsp_lin to 0. No fault gives code 0.
- R12: A table write takes effect only when tbl_wr_ring is 0. Otherwise it leaves the addressed descriptor unchanged. The write address is {tbl_local, tbl_idx}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Descriptor table write strobe |
| tbl_wr_ring | input | 2 | Ring of the writer; only 0 may write |
| tbl_local | input | 1 | Table written: 0 global, 1 local |
| tbl_idx | input | 4 | Entry index written |
| tbl_base | input | 32 | Descriptor base |
| tbl_limit | input | 32 | Descriptor limit (highest valid offset) |
| tbl_rights | input | 3 | {execute, read, write} |
| tbl_dpl | input | 2 | Descriptor ring |
| sreg_we | input | 1 | Selector register write strobe |
| sreg_id | input | 3 | Selector register written (0..5) |
| sreg_val | input | 16 | Selector value |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_kind | input | 3 | Access kind |
| req_ovr_en | input | 1 | Use explicit segment override |
| req_ovr_id | input | 3 | Override segment id |
| req_ring | input | 2 | Ring of the requester |
| req_off | input | 32 | Segment-relative offset |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_lin | output | 32 | Linear address, 0 on fault |
| rsp_fault | output | 3 | Fault code |
| rsp_seg | output | 3 | Segment id used |

## Verification
A selector register or descriptor entry holding the wrong value shows up at the ports in the response to the very next access through it. The symptoms are an rsp_lin offset by the wrong base, a changed fault code, or a wrong rsp_seg. Each such response is one cycle after its request. A stale request or descriptor register shows as a response that changes while it is being held, or as a missing response in the cycle after acceptance. The bench therefore compares every response field against a model built from its own copy of the tables and selectors. It uses random selector, table and request traffic mixed with directed boundary accesses.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  parameter int unsigned LIN_W = 32;
  parameter int unsigned SEL_W = 16;
  parameter int unsigned IDX_W = 13;
  parameter int unsigned NSEG  = 6;

  typedef enum logic [2:0] {
    SEG_CS = 3'd0, SEG_DS = 3'd1, SEG_SS = 3'd2,
    SEG_ES = 3'd3, SEG_FS = 3'd4, SEG_GS = 3'd5
  } seg_id_e;

  typedef enum logic [2:0] {
    ACC_LOAD = 3'd0, ACC_STORE = 3'd1, ACC_FETCH = 3'd2,
    ACC_PUSH = 3'd3, ACC_POP = 3'd4
  } acc_kind_e;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0, FLT_DESC = 3'd1, FLT_PRIV = 3'd2,
    FLT_PROT = 3'd3, FLT_LIMIT = 3'd4
  } fault_e;

  typedef struct packed {
    logic [LIN_W-1:0] base;
    logic [LIN_W-1:0] limit;
    logic             x;
    logic             r;
    logic             w;
    logic [1:0]       ring;
  } desc_t;
endpackage

// File: rtl/seg_sreg_file.sv
module seg_sreg_file
  import seg_xlate_pkg::*;
#(
  parameter int unsigned N = NSEG
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [2:0]       wr_id,
  input  logic [SEL_W-1:0] wr_val,
  input  logic [2:0]       kind,
  input  logic             ovr_en,
  input  logic [2:0]       ovr_id,
  output logic [SEL_W-1:0] sel,
  output logic [2:0]       seg,
  output logic             bad_id
);
  logic [SEL_W-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (we && wr_id == 3'(g))
        regs[g] <= wr_val;
    end
  end

  always_comb begin
    if (ovr_en)
      seg = ovr_id;
    else begin
      case (kind)
        ACC_FETCH:         seg = SEG_CS;
        ACC_PUSH, ACC_POP: seg = SEG_SS;
        default:           seg = SEG_DS;
      endcase
    end
    bad_id = (32'(seg) >= N);
    sel    = bad_id ? '0 : regs[seg];
  end
endmodule

// File: rtl/seg_desc_ram.sv
module seg_desc_ram
  import seg_xlate_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  desc_t         wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output desc_t         rdata
);
  localparam int unsigned DEPTH = 1 << AW;
  desc_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/seg_rights_check.sv
module seg_rights_check
  import seg_xlate_pkg::*;
(
  input  desc_t            desc,
  input  logic [LIN_W-1:0] off,
  input  logic [2:0]       kind,
  input  logic [1:0]       eff_ring,
  input  logic             desc_bad,
  output logic [2:0]       fault,
  output logic [LIN_W-1:0] lin
);
  logic need_x, need_w, need_r, rights_ok;

  always_comb begin
    need_x = (kind == ACC_FETCH);
    need_w = (kind == ACC_STORE) || (kind == ACC_PUSH);
    need_r = !need_x && !need_w;
    rights_ok = !(need_x && !desc.x) && !(need_w && !desc.w) && !(need_r && !desc.r);
    if (desc_bad)                 fault = FLT_DESC;
    else if (eff_ring > desc.ring) fault = FLT_PRIV;
    else if (!rights_ok)          fault = FLT_PROT;
    else if (off > desc.limit)    fault = FLT_LIMIT;
    else                          fault = FLT_NONE;
    lin = (fault == FLT_NONE) ? desc.base + off : '0;
  end
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
#(
  parameter int unsigned TBL_AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tbl_we,
  input  logic [1:0]        tbl_wr_ring,
  input  logic              tbl_local,
  input  logic [TBL_AW-1:0] tbl_idx,
  input  logic [LIN_W-1:0]  tbl_base,
  input  logic [LIN_W-1:0]  tbl_limit,
  input  logic [2:0]        tbl_rights,
  input  logic [1:0]        tbl_dpl,
  input  logic              sreg_we,
  input  logic [2:0]        sreg_id,
  input  logic [SEL_W-1:0]  sreg_val,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic              req_ovr_en,
  input  logic [2:0]        req_ovr_id,
  input  logic [1:0]        req_ring,
  input  logic [LIN_W-1:0]  req_off,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [LIN_W-1:0]  rsp_lin,
  output logic [2:0]        rsp_fault,
  output logic [2:0]        rsp_seg
);
  localparam int unsigned RAM_AW = TBL_AW + 1;

  logic [SEL_W-1:0] cur_sel;
  logic [2:0]       cur_seg;
  logic             cur_bad_id;
  logic [IDX_W-1:0] sel_idx;
  logic             sel_local, sel_oob, sel_null;
  logic [1:0]       sel_rpl, eff_ring;
  logic             accept;
  desc_t            wr_desc, rd_desc;

  logic             v_q;
  logic [LIN_W-1:0] off_q;
  logic [2:0]       kind_q, seg_q;
  logic [1:0]       ring_q;
  logic             bad_q;

  assign req_ready = !v_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  seg_sreg_file u_sregs (
    .clk(clk), .rst(rst), .we(sreg_we), .wr_id(sreg_id), .wr_val(sreg_val),
    .kind(req_kind), .ovr_en(req_ovr_en), .ovr_id(req_ovr_id),
    .sel(cur_sel), .seg(cur_seg), .bad_id(cur_bad_id)
  );

  assign sel_idx   = cur_sel[SEL_W-1:3];
  assign sel_local = cur_sel[2];
  assign sel_rpl   = cur_sel[1:0];
  assign sel_null  = !sel_local && (sel_idx == '0);
  assign eff_ring  = (req_ring > sel_rpl) ? req_ring : sel_rpl;

  if (TBL_AW < IDX_W) begin : g_oob
    assign sel_oob = |sel_idx[IDX_W-1:TBL_AW];
  end else begin : g_no_oob
    assign sel_oob = 1'b0;
  end

  assign wr_desc = '{base: tbl_base, limit: tbl_limit, x: tbl_rights[2],
                     r: tbl_rights[1], w: tbl_rights[0], ring: tbl_dpl};

  seg_desc_ram #(.AW(RAM_AW)) u_ram (
    .clk(clk),
    .we(tbl_we && tbl_wr_ring == 2'd0),
    .waddr({tbl_local, tbl_idx}),
    .wdata(wr_desc),
    .re(accept),
    .raddr({sel_local, sel_idx[TBL_AW-1:0]}),
    .rdata(rd_desc)
  );

  always_ff @(posedge clk) begin
    if (rst)
      v_q <= 1'b0;
    else if (accept)
      v_q <= 1'b1;
    else if (rsp_ready)
      v_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q  <= '0;
      kind_q <= '0;
      seg_q  <= '0;
      ring_q <= '0;
      bad_q  <= 1'b1;
    end else if (accept) begin
      off_q  <= req_off;
      kind_q <= req_kind;
      seg_q  <= cur_seg;
      ring_q <= eff_ring;
      bad_q  <= cur_bad_id || sel_null || sel_oob;
    end
  end

  seg_rights_check u_chk_rights (
    .desc(rd_desc), .off(off_q), .kind(kind_q), .eff_ring(ring_q),
    .desc_bad(bad_q), .fault(rsp_fault), .lin(rsp_lin)
  );

  assign rsp_valid = v_q;
  assign rsp_seg   = seg_q;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_ovr_en,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_lin,
  input logic [2:0]  rsp_fault,
  input logic [2:0]  rsp_seg
);
  assert_accept_resp_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);

  assert_hold_resp_R2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_lin) &&
                                   $stable(rsp_fault) && $stable(rsp_seg)));

  assert_stall_ready_R2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_implicit_seg_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_ovr_en) |=> (rsp_seg <= 3'd2));

  assert_fault_zero_lin_R11: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != 3'd0) |-> (rsp_lin == 32'd0));

  assert_fault_code_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_fault <= 3'd4));
endmodule

bind seg_xlate_top seg_xlate_chk u_seg_xlate_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_ovr_en(req_ovr_en), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_lin(rsp_lin), .rsp_fault(rsp_fault), .rsp_seg(rsp_seg)
);

// File: tb/test_seg_xlate_top.sv
`timescale 1ns/1ps
module test_seg_xlate_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tbl_we = 0, tbl_local = 0;
  logic [1:0]  tbl_wr_ring = 0, tbl_dpl = 0;
  logic [3:0]  tbl_idx = 0;
  logic [31:0] tbl_base = 0, tbl_limit = 0;
  logic [2:0]  tbl_rights = 0;
  logic        sreg_we = 0;
  logic [2:0]  sreg_id = 0;
  logic [15:0] sreg_val = 0;
  logic        req_valid = 0, req_ovr_en = 0, rsp_ready = 1;
  logic        req_ready, rsp_valid;
  logic [2:0]  req_kind = 0, req_ovr_id = 0, rsp_fault, rsp_seg;
  logic [1:0]  req_ring = 0;
  logic [31:0] req_off = 0, rsp_lin;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_base [32];
  logic [31:0] m_lim  [32];
  logic [2:0]  m_rt   [32];
  logic [1:0]  m_dpl  [32];
  logic [15:0] m_sreg [6];

  always #4 clk = ~clk;

  seg_xlate_top i_seg_xlate_top (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [2:0] kind, input logic oen, input logic [2:0] oid,
                       input logic [1:0] ring, input logic [31:0] off,
                       output logic [2:0] seg, output logic [2:0] flt, output logic [31:0] lin);
    logic [15:0] sel; int idx, a; logic [1:0] er; logic ok;
    seg = oen ? oid : (kind == 3'd2) ? 3'd0 : (kind == 3'd3 || kind == 3'd4) ? 3'd2 : 3'd1;
    lin = 0;
    if (seg > 3'd5) begin flt = 3'd1; return; end
    sel = m_sreg[seg];
    idx = int'(sel[15:3]);
    if ((!sel[2] && idx == 0) || idx >= 16) begin flt = 3'd1; return; end
    a  = (sel[2] ? 16 : 0) + idx;
    er = (ring > sel[1:0]) ? ring : sel[1:0];
    case (kind)
      3'd2:       ok = m_rt[a][2];
      3'd1, 3'd3: ok = m_rt[a][0];
      default:    ok = m_rt[a][1];
    endcase
    if (er > m_dpl[a])          flt = 3'd2;
    else if (!ok)               flt = 3'd3;
    else if (off > m_lim[a])    flt = 3'd4;
    else begin flt = 3'd0; lin = m_base[a] + off; end
  endtask

  task automatic tbl_write(input logic loc, input int idx, input logic [31:0] b,
                           input logic [31:0] l, input logic [2:0] rt,
                           input logic [1:0] dpl, input logic [1:0] wr);
    @(negedge clk);
    tbl_we = 1; tbl_local = loc; tbl_idx = 4'(idx); tbl_base = b; tbl_limit = l;
    tbl_rights = rt; tbl_dpl = dpl; tbl_wr_ring = wr;
    @(negedge clk);
    tbl_we = 0;
    if (wr == 2'd0) begin
      m_base[(loc ? 16 : 0) + idx] = b; m_lim[(loc ? 16 : 0) + idx] = l;
      m_rt[(loc ? 16 : 0) + idx] = rt; m_dpl[(loc ? 16 : 0) + idx] = dpl;
    end
  endtask

  task automatic sreg_write(input int id, input logic [15:0] v);
    @(negedge clk);
    sreg_we = 1; sreg_id = 3'(id); sreg_val = v;
    @(negedge clk);
    sreg_we = 0;
    m_sreg[id] = v;
  endtask

  task automatic xact(input string tag, input logic [2:0] kind, input logic oen,
                      input logic [2:0] oid, input logic [1:0] ring, input logic [31:0] off,
                      input logic use_exp, input logic [2:0] e_flt, input logic [31:0] e_lin);
    logic [2:0] seg, flt; logic [31:0] lin;
    model(kind, oen, oid, ring, off, seg, flt, lin);
    if (use_exp) begin flt = e_flt; lin = e_lin; end
    @(negedge clk);
    req_valid = 1; req_kind = kind; req_ovr_en = oen; req_ovr_id = oid;
    req_ring = ring; req_off = off;
    @(negedge clk);
    req_valid = 0;
    check({tag, " valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " seg"},   32'(rsp_seg),   32'(seg));
    check({tag, " fault"}, 32'(rsp_fault), 32'(flt));
    check({tag, " lin"},   rsp_lin,        lin);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] h_lin; logic [2:0] h_flt;
    void'($urandom(32'h5EC7_0A11));
    for (int i = 0; i < 6; i++) m_sreg[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 req_ready", 32'(req_ready), 32'd1);
    check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    xact("R1 null after reset", 3'd2, 0, 0, 0, 32'h100, 1, 3'd1, 32'd0);

    for (int i = 0; i < 32; i++)
      tbl_write(i >= 16, i % 16, $urandom, ($urandom % 2) ? 32'hFFFF_FFFF : ($urandom & 32'h1FFFF),
                3'($urandom), 2'($urandom), 2'd0);
    tbl_write(0, 1, 32'h0, 32'hFFFF_FFFF, 3'b110, 2'd0, 2'd0);           // flat code
    tbl_write(0, 2, 32'h0, 32'hFFFF_FFFF, 3'b011, 2'd0, 2'd0);           // flat data
    tbl_write(0, 3, 32'h1000_0000, 32'hFFFF_FFFF, 3'b110, 2'd0, 2'd0);   // shifted code
    tbl_write(1, 1, 32'h4000_0000, 32'h0000_0FFF, 3'b011, 2'd3, 2'd0);   // user data
    tbl_write(1, 2, 32'h0000_1000, 32'h0000_FFFF, 3'b010, 2'd3, 2'd0);   // read-only
    tbl_write(1, 3, 32'h0080_0000, 32'hFFFF_FFFF, 3'b011, 2'd0, 2'd0);   // stack
    sreg_write(0, 16'h0008); sreg_write(1, 16'h0010); sreg_write(2, 16'h001C);
    sreg_write(3, 16'h000F); sreg_write(4, 16'h0017); sreg_write(5, 16'h0018);

    // R12 write from ring 1 is ignored
    tbl_write(0, 1, 32'h5555_0000, 32'h0, 3'b000, 2'd3, 2'd1);
    xact("R12 ignored write", 3'd2, 0, 0, 0, 32'h1234, 1, 3'd0, 32'h1234);
    // R3 implicit choice, R5 sum
    xact("R3 fetch CS", 3'd2, 0, 0, 0, 32'hABC, 1, 3'd0, 32'hABC);
    xact("R3 push SS", 3'd3, 0, 0, 0, 32'h40, 1, 3'd0, 32'h0080_0040);
    xact("R3 pop SS", 3'd4, 0, 0, 0, 32'h44, 1, 3'd0, 32'h0080_0044);
    xact("R3 load DS", 3'd0, 0, 0, 0, 32'h80, 1, 3'd0, 32'h80);
    xact("R3 store DS", 3'd1, 0, 0, 0, 32'h84, 1, 3'd0, 32'h84);
    xact("R5 wrap", 3'd2, 1, 3'd5, 0, 32'hF010_0000, 1, 3'd0, 32'h0010_0000);
    // R4 override
    xact("R4 ES", 3'd0, 1, 3'd3, 3, 32'h10, 1, 3'd0, 32'h4000_0010);
    xact("R4 bad id 6", 3'd0, 1, 3'd6, 0, 32'h10, 1, 3'd1, 32'd0);
    xact("R4 bad id 7", 3'd0, 1, 3'd7, 0, 32'h10, 1, 3'd1, 32'd0);
    // R8 limit edge
    xact("R8 at limit", 3'd0, 1, 3'd3, 3, 32'hFFF, 1, 3'd0, 32'h4000_0FFF);
    xact("R8 past limit", 3'd0, 1, 3'd3, 3, 32'h1000, 1, 3'd4, 32'd0);
    // R9 rights
    xact("R9 store ro", 3'd1, 1, 3'd4, 3, 32'h8, 1, 3'd3, 32'd0);
    xact("R9 load ro", 3'd0, 1, 3'd4, 3, 32'h8, 1, 3'd0, 32'h1008);
    xact("R9 fetch data", 3'd2, 1, 3'd1, 0, 32'h8, 1, 3'd3, 32'd0);
    xact("R9 write code", 3'd1, 1, 3'd0, 0, 32'h8, 1, 3'd3, 32'd0);
    // R10 / R6 privilege
    xact("R10 ring3 on ring0", 3'd0, 0, 0, 3, 32'h8, 1, 3'd2, 32'd0);
    sreg_write(3, 16'h001E);
    xact("R6 selector ring raises", 3'd0, 1, 3'd3, 0, 32'h8, 1, 3'd2, 32'd0);
    sreg_write(3, 16'h001C);
    xact("R6 local idx3 ring0", 3'd0, 1, 3'd3, 0, 32'h8, 1, 3'd0, 32'h0080_0008);
    // R11 priority
    xact("R11 priv over prot", 3'd2, 1, 3'd1, 3, 32'h8, 1, 3'd2, 32'd0);
    xact("R11 prot over limit", 3'd1, 1, 3'd4, 3, 32'h2_0000, 1, 3'd3, 32'd0);
    // R7 null and out of range
    sreg_write(3, 16'h0003);
    xact("R7 global null", 3'd0, 1, 3'd3, 0, 32'h8, 1, 3'd1, 32'd0);
    sreg_write(3, 16'h0080);
    xact("R7 index at depth", 3'd0, 1, 3'd3, 0, 32'h8, 1, 3'd1, 32'd0);
    sreg_write(3, 16'h0004);
    xact("R7 local zero usable", 3'd0, 1, 3'd3, 0, 32'h8, 0, 3'd0, 32'd0);

    // R2 back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_kind = 3'd0; req_ovr_en = 1; req_ovr_id = 3'd3;
    req_ring = 0; req_off = 32'h20;
    model(3'd0, 1, 3'd3, 0, 32'h20, req_kind, h_flt, h_lin);
    req_kind = 3'd0;
    @(negedge clk);
    req_valid = 0;
    check("R2 valid after accept", 32'(rsp_valid), 32'd1);
    check("R2 ready low on stall", 32'(req_ready), 32'd0);
    req_valid = 1; req_off = 32'h30;
    repeat (2) @(negedge clk);
    check("R2 held lin", rsp_lin, h_lin);
    check("R2 held fault", 32'(rsp_fault), 32'(h_flt));
    req_valid = 0;
    rsp_ready = 1;
    #1;
    check("R2 ready when consumed", 32'(req_ready), 32'd1);
    @(negedge clk);
    check("R2 drained", 32'(rsp_valid), 32'd0);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int r; r = int'($urandom % 10);
      if (r == 0)
        sreg_write(int'($urandom % 6), {13'($urandom % 20), 1'($urandom), 2'($urandom)});
      else if (r == 1)
        tbl_write(1'($urandom), int'($urandom % 16), $urandom,
                  ($urandom % 2) ? 32'hFFFF_FFFF : ($urandom & 32'h1FFFF), 3'($urandom),
                  2'($urandom), ($urandom % 4 == 0) ? 2'($urandom) : 2'd0);
      else
        xact("R3/R4/R5/R8/R9/R10/R11 random", 3'($urandom % 5), ($urandom % 4 == 0),
             3'($urandom), 2'($urandom), ($urandom % 2) ? $urandom : ($urandom & 32'h1FFFF),
             0, 3'd0, 32'd0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule